// File: doc/BRIEF.md
# Indirect Address-Table Access Port

This block holds a switch's address table in on-chip RAM and lets software reach it only through a narrow 32-bit register bus. Each entry is 68 bits wide, so one entry does not fit in a bus word. Software stages an entry in three data words. It then writes an entry index to a table-control register. Bit 31 of that write decides the direction. When it is set, the staged words are committed to the entry. When it is clear, the entry is fetched back into the staged words.

A global control register holds an enable flag and a clear trigger. The clear trigger zeroes the whole table, one entry per clock. Because a zeroed entry has type code 0, every entry reads as free after a clear. A read-only identification register reports the major and minor revision. The block does not look up, learn or age addresses on live traffic.

Top module: `addr_table_port`

## Requirements
- R1: A read at offset 0x00 returns the revision word: major revision in bits 15:8, minor revision in bits 7:0, all other bits 0. Every read returns its data with `bus_rvalid` high on the cycle after `bus_rd`.
- R2: The data words map entry bits as follows: offset 0x3C holds bits 31:0, offset 0x38 holds bits 63:32, and offset 0x34 holds bits 67:64 in its bits 3:0. Bits 31:4 at 0x34 always read 0.
- R3: A write to offset 0x20 with bit 31 set and an index in bits 9:0 stores the three staged words into that entry.
- R4: A write to offset 0x20 with bit 31 clear loads the indexed entry into the three data words. The new contents can be read from the second cycle after the write.
- R5: Bit 31 of the control register at offset 0x08 is a read/write enable flag.
- R6: Writing 1 to control bit 30 zeroes every entry, one per clock, over DEPTH cycles. Bit 30 reads 1 while this runs and 0 afterwards. Every entry then has type field bits 61:60 equal to 0 (free).
- R7: A table-control write whose index is DEPTH or above is ignored. No entry is written, and the data words keep their values.
- R8: Table-control writes that arrive while a clear is running are ignored.
- R9: A read of offset 0x20 returns the last accepted index in bits 9:0, with bit 31 reading 0.
- R10: Reads of undefined offsets return 0, and writes to the revision register have no effect.
- R11: After reset, the control register, the table-control register and all three data words read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |

## Verification
The table is visible only through fetches, so a wrong entry, a stuck write enable or an aliased index stays hidden until software fetches the affected entry. The fault then shows in the data words two cycles after that fetch. A clear walk that stalls or ends early appears sooner: control bit 30 fails to fall after DEPTH cycles, or an entry that should have been zeroed comes back non-zero. An ignored index that still writes the table is caught by fetching the entry it would alias to. An ignored fetch that still disturbs the staged words shows on the very next data-word read.

// File: rtl/atp_pkg.sv
package atp_pkg;
  localparam int WORD_W    = 32;
  localparam int ENTRY_W   = 68;
  localparam int HI_W      = ENTRY_W - 2 * WORD_W;
  localparam int IDXF_W    = 10;

  localparam logic [7:0] OFF_REV  = 8'h00;
  localparam logic [7:0] OFF_CTRL = 8'h08;
  localparam logic [7:0] OFF_TCTL = 8'h20;
  localparam logic [7:0] OFF_WHI  = 8'h34;
  localparam logic [7:0] OFF_WMID = 8'h38;
  localparam logic [7:0] OFF_WLO  = 8'h3C;

  localparam int EN_BIT  = 31;
  localparam int CLR_BIT = 30;
  localparam int DIR_BIT = 31;

  typedef struct packed {
    logic [HI_W-1:0]   hi;
    logic [WORD_W-1:0] mid;
    logic [WORD_W-1:0] lo;
  } entry_t;
endpackage

// File: rtl/atp_entry_ram.sv
module atp_entry_ram #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 68,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/atp_clear_sweep.sv
module atp_clear_sweep #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          busy,
  output logic          we,
  output logic [AW-1:0] addr
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic          busy_q;
  logic [AW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == LAST) busy_q <= 1'b0;
      else cnt_q <= cnt_q + 1'b1;
    end
  end

  assign busy = busy_q;
  assign we   = busy_q;
  assign addr = cnt_q;
endmodule

// File: rtl/addr_table_port.sv
module addr_table_port
  import atp_pkg::*;
#(
  parameter int          DEPTH     = 64,
  parameter logic [7:0]  REV_MAJOR = 8'h01,
  parameter logic [7:0]  REV_MINOR = 8'h03
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        bus_rvalid
);
  localparam int IDX_W = $clog2(DEPTH);

  logic              en_q;
  logic [IDXF_W-1:0] idx_q;
  entry_t            data_q;
  logic              fetch_pend;
  logic [31:0]       rdata_q;
  logic              rvalid_q;

  logic              sweep_busy, sweep_we;
  logic [IDX_W-1:0]  sweep_addr;
  logic [ENTRY_W-1:0] ram_dout;

  logic tctl_wr, idx_ok, accept, commit, fetch, clear_start;
  logic              ram_we;
  logic [IDX_W-1:0]  ram_waddr;
  logic [ENTRY_W-1:0] ram_wdata;
  logic [31:0]       rd_mux;

  assign tctl_wr     = bus_wr && (bus_addr == OFF_TCTL);
  assign idx_ok      = (32'(bus_wdata[IDXF_W-1:0]) < 32'(DEPTH));
  assign accept      = tctl_wr && idx_ok && !sweep_busy;
  assign commit      = accept && bus_wdata[DIR_BIT];
  assign fetch       = accept && !bus_wdata[DIR_BIT];
  assign clear_start = bus_wr && (bus_addr == OFF_CTRL) && bus_wdata[CLR_BIT] && !sweep_busy;

  assign ram_we    = sweep_we || commit;
  assign ram_waddr = sweep_we ? sweep_addr : bus_wdata[IDX_W-1:0];
  assign ram_wdata = sweep_we ? '0 : data_q;

  atp_clear_sweep #(.DEPTH(DEPTH)) u_sweep (
    .clk   (clk),
    .rst   (rst),
    .start (clear_start),
    .busy  (sweep_busy),
    .we    (sweep_we),
    .addr  (sweep_addr)
  );

  atp_entry_ram #(.DEPTH(DEPTH), .WIDTH(ENTRY_W)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .re    (fetch),
    .raddr (bus_wdata[IDX_W-1:0]),
    .rdata (ram_dout)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q       <= 1'b0;
      idx_q      <= '0;
      data_q     <= '0;
      fetch_pend <= 1'b0;
    end else begin
      fetch_pend <= fetch;
      if (bus_wr && bus_addr == OFF_CTRL) en_q <= bus_wdata[EN_BIT];
      if (accept) idx_q <= bus_wdata[IDXF_W-1:0];
      if (bus_wr && bus_addr == OFF_WHI)  data_q.hi  <= bus_wdata[HI_W-1:0];
      if (bus_wr && bus_addr == OFF_WMID) data_q.mid <= bus_wdata;
      if (bus_wr && bus_addr == OFF_WLO)  data_q.lo  <= bus_wdata;
      if (fetch_pend) data_q <= entry_t'(ram_dout);
    end
  end

  always_comb begin
    case (bus_addr)
      OFF_REV:  rd_mux = {16'h0, REV_MAJOR, REV_MINOR};
      OFF_CTRL: rd_mux = {en_q, sweep_busy, 30'h0};
      OFF_TCTL: rd_mux = {{(32-IDXF_W){1'b0}}, idx_q};
      OFF_WHI:  rd_mux = {{(32-HI_W){1'b0}}, data_q.hi};
      OFF_WMID: rd_mux = data_q.mid;
      OFF_WLO:  rd_mux = data_q.lo;
      default:  rd_mux = 32'h0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= bus_rd;
      rdata_q  <= bus_rd ? rd_mux : 32'h0;
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;
endmodule

// File: rtl/atp_checker.sv
module atp_checker
  import atp_pkg::*;
#(
  parameter int         DEPTH     = 64,
  parameter logic [7:0] REV_MAJOR = 8'h01,
  parameter logic [7:0] REV_MINOR = 8'h03
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [7:0]        bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              bus_rvalid,
  input logic              sweep_busy,
  input logic              fetch_pend,
  input logic [ENTRY_W-1:0] data_words,
  input logic [IDXF_W-1:0] idx_q
);
  assert_read_latency_R1: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid);

  assert_rev_value_R1: assert property (@(posedge clk) disable iff (rst)
    (bus_rvalid && $past(bus_addr) == OFF_REV) |-> bus_rdata == {16'h0, REV_MAJOR, REV_MINOR});

  assert_hi_word_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_rvalid && $past(bus_addr) == OFF_WHI) |-> bus_rdata[31:HI_W] == '0);

  assert_clear_starts_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == OFF_CTRL && bus_wdata[CLR_BIT]) |=> sweep_busy);

  assert_bad_index_keeps_data_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == OFF_TCTL && 32'(bus_wdata[IDXF_W-1:0]) >= 32'(DEPTH) && !fetch_pend)
      |=> $stable(data_words));

  assert_busy_blocks_access_R8: assert property (@(posedge clk) disable iff (rst)
    (sweep_busy && bus_wr && bus_addr == OFF_TCTL) |=> $stable(idx_q));
endmodule

bind addr_table_port atp_checker #(
  .DEPTH(DEPTH), .REV_MAJOR(REV_MAJOR), .REV_MINOR(REV_MINOR)
) u_atp_checker (
  .clk        (clk),
  .rst        (rst),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .bus_rvalid (bus_rvalid),
  .sweep_busy (sweep_busy),
  .fetch_pend (fetch_pend),
  .data_words (data_q),
  .idx_q      (idx_q)
);

// File: tb/test_addr_table_port.sv
module test_addr_table_port;
  localparam int DEPTH = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [31:0] exp;
    logic [7:0]  addr;
    string       tag;
  } item_t;
  item_t exp_q[$];

  always #2.5 clk = ~clk;

  addr_table_port #(.DEPTH(DEPTH), .REV_MAJOR(8'h01), .REV_MINOR(8'h03)) i_addr_table_port (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
  );

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    item_t it;
    it.exp = e; it.addr = a; it.tag = tag;
    exp_q.push_back(it);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      item_t it;
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL unexpected read data: actual %h expected none", bus_rdata);
      end else begin
        it = exp_q.pop_front();
        if (bus_rdata !== it.exp) begin
          errors++;
          $display("FAIL %s offset %h: actual %h expected %h", it.tag, it.addr, bus_rdata, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(4);
    rst = 1'b0;
    idle(1);
    // R11 reset state
    rd(8'h08, 32'h0, "R11");
    rd(8'h20, 32'h0, "R11");
    rd(8'h34, 32'h0, "R11");
    rd(8'h38, 32'h0, "R11");
    rd(8'h3C, 32'h0, "R11");
    // R1 revision, R10 write ignored and undefined offset
    rd(8'h00, 32'h0000_0103, "R1");
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, 32'h0000_0103, "R10");
    rd(8'h44, 32'h0, "R10");
    // R6 clear with enable (R5)
    wr(8'h08, 32'hC000_0000);
    rd(8'h08, 32'hC000_0000, "R6");
    idle(DEPTH + 4);
    rd(8'h08, 32'h8000_0000, "R6");
    // R2 data word staging
    wr(8'h34, 32'hFFFF_FFF5);
    wr(8'h38, 32'h1234_5678);
    wr(8'h3C, 32'h9ABC_DEF0);
    rd(8'h34, 32'h0000_0005, "R2");
    rd(8'h38, 32'h1234_5678, "R2");
    rd(8'h3C, 32'h9ABC_DEF0, "R2");
    // R3 commit to 5 and 63
    wr(8'h20, 32'h8000_0005);
    rd(8'h20, 32'h0000_0005, "R9");
    wr(8'h34, 32'h0000_000A);
    wr(8'h38, 32'h1111_1111);
    wr(8'h3C, 32'h2222_2222);
    wr(8'h20, 32'h8000_003F);
    // R4 fetch back
    wr(8'h20, 32'h0000_0005);
    idle(2);
    rd(8'h34, 32'h0000_0005, "R3");
    rd(8'h38, 32'h1234_5678, "R4");
    rd(8'h3C, 32'h9ABC_DEF0, "R4");
    wr(8'h20, 32'h0000_003F);
    idle(2);
    rd(8'h34, 32'h0000_000A, "R4");
    rd(8'h38, 32'h1111_1111, "R3");
    rd(8'h3C, 32'h2222_2222, "R4");
    // R7 out-of-range index ignored
    wr(8'h38, 32'h5555_AAAA);
    wr(8'h20, 32'h8000_0040);
    wr(8'h20, 32'h0000_0040);
    idle(2);
    rd(8'h38, 32'h5555_AAAA, "R7");
    rd(8'h20, 32'h0000_003F, "R7");
    wr(8'h20, 32'h0000_0000);
    idle(2);
    rd(8'h38, 32'h0000_0000, "R7");
    // R8 access during clear ignored
    wr(8'h08, 32'hC000_0000);
    wr(8'h38, 32'h7777_7777);
    wr(8'h20, 32'h8000_0007);
    rd(8'h20, 32'h0000_0000, "R8");
    idle(DEPTH + 4);
    wr(8'h20, 32'h0000_0007);
    idle(2);
    rd(8'h38, 32'h0000_0000, "R8");
    // R6 entry 5 now free: type bits 61:60 zero
    wr(8'h20, 32'h0000_0005);
    idle(2);
    rd(8'h38, 32'h0000_0000, "R6");
    rd(8'h34, 32'h0000_0000, "R6");
    // R5 enable cleared
    wr(8'h08, 32'h0000_0000);
    rd(8'h08, 32'h0000_0000, "R5");
    idle(4);
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R1 reads pending: actual %0d expected 0", exp_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule